// File: doc/BRIEF.md
# Scheduled Radio State Sequencer

This block times the transitions of a radio front end against a free-running 32-bit timebase supplied from outside. Software schedules one of two operations. A transmit gives an absolute start time, an idle-to-transmit delay and an amplifier ramp length. A receive gives an absolute start time and a window length. The block holds the deadlines it derives from these values and compares each one against the timebase. It compares by the sign of the 32-bit difference, so a deadline that lies across the rollover of the counter is still handled in order.

During a transmit, radio active rises at the start time. The transmit-amplifier enable rises later, when the delay has run out, and a ramp-start strobe fires with it. A modulation-start strobe fires when the ramp period ends. The transmit then holds until the modem reports that it is done. During a receive, radio active and the receive-amplifier enable rise at the start time. If a sync word arrives inside the window, the receive stays up until the modem reports completion. If no sync word arrives, a timeout strobe fires at the end of the window. An abort input ends any operation at once.

Every output is registered. An event whose deadline is D takes effect on the clock edge after the first edge at which the sequencer is in the phase before that event and the sampled timebase minus D, read as a signed 32-bit value, is not negative. Each phase therefore lasts at least one clock, and a zero-length delay or ramp costs one cycle.

Top module: `radio_seq_top`

## Requirements
- R1: After reset all outputs are low and the sequencer is idle.
- R2: After a transmit is armed with start time S, radio active rises on the edge after the edge that samples timebase S. The transmit-amplifier enable stays low through the idle-to-transmit delay.
- R3: With delay I, a one-cycle ramp-start strobe and the rise of the transmit-amplifier enable appear together on the edge after the edge that samples timebase S+I.
- R4: With ramp length P, a one-cycle modulation-start strobe appears on the edge after the edge that samples S+I+P. The transmit-amplifier enable stays high after it.
- R5: A transmit-done pulse during modulation returns the sequencer to idle, and all enables are low after the next edge. The transmit-amplifier enable falls only on transmit-done or abort.
- R6: After a receive is armed with start time S, radio active and the receive-amplifier enable rise on the edge after the edge that samples S.
- R7: With window W and no sync, a one-cycle receive-timeout strobe appears on the edge after the edge that samples S+W. Radio active and the receive-amplifier enable drop on that same edge.
- R8: Sync seen while the window is open stops the window. No timeout follows, and the receive stays active until a receive-done pulse, after which all enables are low. Sync has priority over a timeout on the same edge.
- R9: Abort returns the sequencer to idle from any state on the next edge. It clears all enables, suppresses every strobe, and wins over an arm request on the same edge.
- R10: A start time whose signed 32-bit difference from the timebase at arming is negative starts the sequence on the first edge after the arming edge. Deadlines that cross the timebase rollover fire in order and not early.
- R11: Arm requests are accepted only in idle and are ignored otherwise. A transmit arm wins over a receive arm on the same edge.
- R12: The receive- and transmit-amplifier enables are never high together, and either one high implies radio active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timebase_i | input | 32 | Free-running microsecond timebase |
| tx_arm_i | input | 1 | Schedule a transmit (pulse) |
| tx_start_time_i | input | 32 | Absolute transmit start time |
| tx_idle_dly_i | input | 16 | Idle-to-transmit delay in timebase ticks |
| tx_ramp_len_i | input | 16 | Amplifier ramp length in timebase ticks |
| rx_arm_i | input | 1 | Schedule a receive window (pulse) |
| rx_start_time_i | input | 32 | Absolute receive start time |
| rx_window_len_i | input | 16 | Receive window length in timebase ticks |
| sync_det_i | input | 1 | Sync word detected |
| tx_done_i | input | 1 | Transmit finished |
| rx_done_i | input | 1 | Receive finished |
| abort_i | input | 1 | Return to idle immediately |
| radio_active_o | output | 1 | Radio on (receive or transmit) |
| rx_amp_en_o | output | 1 | Receive amplifier enable |
| tx_amp_en_o | output | 1 | Transmit amplifier enable |
| ramp_start_o | output | 1 | Strobe at amplifier ramp start |
| mod_start_o | output | 1 | Strobe at modulation start |
| rx_timeout_o | output | 1 | Strobe when the receive window closes without sync |

## Verification
The assertions check on every cycle the rules that hold no matter what was scheduled. These are exclusive amplifier enables, active covering both enables, at most one strobe, a ramp strobe that coincides with a fresh transmit enable, and a modulation strobe only after the ramp. They also check that abort clears everything on the next edge, that a timeout closes the window, and that an enable falls only for a permitted reason. Only the bench scenarios can show that each event lands on the correct timebase value. The same holds for a past start time firing at once, for a wrapped deadline not firing early, and for arm requests in busy states leaving the running sequence unchanged. The bench covers these with a reference model compared on every clock and with timestamp checks per scenario.

// File: rtl/radio_seq_pkg.sv
`timescale 1ns/1ps
package radio_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_WAIT,
    ST_TX_DELAY,
    ST_TX_RAMP,
    ST_TX_MOD,
    ST_RX_WAIT,
    ST_RX_WIN,
    ST_RX_SYNC
  } seq_state_e;

  localparam int unsigned NUM_DL  = 3;
  localparam int unsigned DL_T0   = 0;  // start
  localparam int unsigned DL_T1   = 1;  // ramp start / window end
  localparam int unsigned DL_T2   = 2;  // modulation start
endpackage

// File: rtl/rs_time_cmp.sv
`timescale 1ns/1ps
module rs_time_cmp #(
  parameter int unsigned TW = 32
) (
  input  logic [TW-1:0] timebase_i,
  input  logic [TW-1:0] deadline_i,
  output logic          reached_o
);
  logic [TW-1:0] diff;

  // wrap-aware: reached when signed(tb - dl) >= 0
  always_comb begin
    diff      = timebase_i - deadline_i;
    reached_o = ~diff[TW-1];
  end
endmodule

// File: rtl/rs_deadline_regs.sv
`timescale 1ns/1ps
module rs_deadline_regs
  import radio_seq_pkg::*;
#(
  parameter int unsigned TW = 32,
  parameter int unsigned DW = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_tx_i,
  input  logic                       load_rx_i,
  input  logic [TW-1:0]              tx_start_i,
  input  logic [DW-1:0]              tx_idle_i,
  input  logic [DW-1:0]              tx_ramp_i,
  input  logic [TW-1:0]              rx_start_i,
  input  logic [DW-1:0]              rx_win_i,
  output logic [NUM_DL-1:0][TW-1:0]  dl_o
);
  logic [TW-1:0] tx_ramp_at;
  logic [TW-1:0] tx_mod_at;
  logic [TW-1:0] rx_end_at;

  always_comb begin
    tx_ramp_at = tx_start_i + TW'(tx_idle_i);
    tx_mod_at  = tx_ramp_at + TW'(tx_ramp_i);
    rx_end_at  = rx_start_i + TW'(rx_win_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_o <= '0;
    end else if (load_tx_i) begin
      dl_o[DL_T0] <= tx_start_i;
      dl_o[DL_T1] <= tx_ramp_at;
      dl_o[DL_T2] <= tx_mod_at;
    end else if (load_rx_i) begin
      dl_o[DL_T0] <= rx_start_i;
      dl_o[DL_T1] <= rx_end_at;
      dl_o[DL_T2] <= rx_end_at;
    end
  end
endmodule

// File: rtl/rs_seq_fsm.sv
`timescale 1ns/1ps
module rs_seq_fsm
  import radio_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_arm_i,
  input  logic              rx_arm_i,
  input  logic              sync_det_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              abort_i,
  input  logic [NUM_DL-1:0] reached_i,
  output seq_state_e        state_d_o,
  output logic              load_tx_o,
  output logic              load_rx_o,
  output logic              ev_ramp_o,
  output logic              ev_mod_o,
  output logic              ev_tmo_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_tx_o = 1'b0;
    load_rx_o = 1'b0;
    ev_ramp_o = 1'b0;
    ev_mod_o  = 1'b0;
    ev_tmo_o  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (tx_arm_i) begin
            state_d   = ST_TX_WAIT;
            load_tx_o = 1'b1;
          end else if (rx_arm_i) begin
            state_d   = ST_RX_WAIT;
            load_rx_o = 1'b1;
          end
        end
        ST_TX_WAIT:  if (reached_i[DL_T0]) state_d = ST_TX_DELAY;
        ST_TX_DELAY: if (reached_i[DL_T1]) begin
          state_d   = ST_TX_RAMP;
          ev_ramp_o = 1'b1;
        end
        ST_TX_RAMP:  if (reached_i[DL_T2]) begin
          state_d  = ST_TX_MOD;
          ev_mod_o = 1'b1;
        end
        ST_TX_MOD:   if (tx_done_i) state_d = ST_IDLE;
        ST_RX_WAIT:  if (reached_i[DL_T0]) state_d = ST_RX_WIN;
        ST_RX_WIN: begin
          if (sync_det_i) begin
            state_d = ST_RX_SYNC;
          end else if (reached_i[DL_T1]) begin
            state_d  = ST_IDLE;
            ev_tmo_o = 1'b1;
          end
        end
        ST_RX_SYNC:  if (rx_done_i) state_d = ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
endmodule

// File: rtl/rs_out_stage.sv
`timescale 1ns/1ps
module rs_out_stage
  import radio_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e state_d_i,
  input  logic       ev_ramp_i,
  input  logic       ev_mod_i,
  input  logic       ev_tmo_i,
  output logic       radio_active_o,
  output logic       rx_amp_en_o,
  output logic       tx_amp_en_o,
  output logic       ramp_start_o,
  output logic       mod_start_o,
  output logic       rx_timeout_o
);
  logic tx_en_d, rx_en_d, act_d;

  always_comb begin
    tx_en_d = (state_d_i == ST_TX_RAMP) || (state_d_i == ST_TX_MOD);
    rx_en_d = (state_d_i == ST_RX_WIN)  || (state_d_i == ST_RX_SYNC);
    act_d   = tx_en_d || rx_en_d || (state_d_i == ST_TX_DELAY);
  end

  // registered so front-end pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      radio_active_o <= 1'b0;
      rx_amp_en_o    <= 1'b0;
      tx_amp_en_o    <= 1'b0;
      ramp_start_o   <= 1'b0;
      mod_start_o    <= 1'b0;
      rx_timeout_o   <= 1'b0;
    end else begin
      radio_active_o <= act_d;
      rx_amp_en_o    <= rx_en_d;
      tx_amp_en_o    <= tx_en_d;
      ramp_start_o   <= ev_ramp_i;
      mod_start_o    <= ev_mod_i;
      rx_timeout_o   <= ev_tmo_i;
    end
  end
endmodule

// File: rtl/radio_seq_top.sv
`timescale 1ns/1ps
module radio_seq_top
  import radio_seq_pkg::*;
#(
  parameter int unsigned TW = 32,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] timebase_i,
  input  logic          tx_arm_i,
  input  logic [TW-1:0] tx_start_time_i,
  input  logic [DW-1:0] tx_idle_dly_i,
  input  logic [DW-1:0] tx_ramp_len_i,
  input  logic          rx_arm_i,
  input  logic [TW-1:0] rx_start_time_i,
  input  logic [DW-1:0] rx_window_len_i,
  input  logic          sync_det_i,
  input  logic          tx_done_i,
  input  logic          rx_done_i,
  input  logic          abort_i,
  output logic          radio_active_o,
  output logic          rx_amp_en_o,
  output logic          tx_amp_en_o,
  output logic          ramp_start_o,
  output logic          mod_start_o,
  output logic          rx_timeout_o
);
  logic [NUM_DL-1:0][TW-1:0] dl;
  logic [NUM_DL-1:0]         reached;
  logic                      load_tx, load_rx;
  logic                      ev_ramp, ev_mod, ev_tmo;
  seq_state_e                state_d;

  rs_deadline_regs #(.TW(TW), .DW(DW)) u_dl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_tx_i  (load_tx),
    .load_rx_i  (load_rx),
    .tx_start_i (tx_start_time_i),
    .tx_idle_i  (tx_idle_dly_i),
    .tx_ramp_i  (tx_ramp_len_i),
    .rx_start_i (rx_start_time_i),
    .rx_win_i   (rx_window_len_i),
    .dl_o       (dl)
  );

  for (genvar g = 0; g < NUM_DL; g++) begin : g_cmp
    rs_time_cmp #(.TW(TW)) u_cmp (
      .timebase_i (timebase_i),
      .deadline_i (dl[g]),
      .reached_o  (reached[g])
    );
  end

  rs_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_arm_i   (tx_arm_i),
    .rx_arm_i   (rx_arm_i),
    .sync_det_i (sync_det_i),
    .tx_done_i  (tx_done_i),
    .rx_done_i  (rx_done_i),
    .abort_i    (abort_i),
    .reached_i  (reached),
    .state_d_o  (state_d),
    .load_tx_o  (load_tx),
    .load_rx_o  (load_rx),
    .ev_ramp_o  (ev_ramp),
    .ev_mod_o   (ev_mod),
    .ev_tmo_o   (ev_tmo)
  );

  rs_out_stage u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_d_i      (state_d),
    .ev_ramp_i      (ev_ramp),
    .ev_mod_i       (ev_mod),
    .ev_tmo_i       (ev_tmo),
    .radio_active_o (radio_active_o),
    .rx_amp_en_o    (rx_amp_en_o),
    .tx_amp_en_o    (tx_amp_en_o),
    .ramp_start_o   (ramp_start_o),
    .mod_start_o    (mod_start_o),
    .rx_timeout_o   (rx_timeout_o)
  );
endmodule

// File: rtl/radio_seq_chk.sv
`timescale 1ns/1ps
module radio_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_done_i,
  input logic rx_done_i,
  input logic abort_i,
  input logic radio_active_o,
  input logic rx_amp_en_o,
  input logic tx_amp_en_o,
  input logic ramp_start_o,
  input logic mod_start_o,
  input logic rx_timeout_o
);
  // R12
  amps_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_amp_en_o && tx_amp_en_o));
  // R12
  amp_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_amp_en_o || tx_amp_en_o) |-> radio_active_o);
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ramp_start_o, mod_start_o, rx_timeout_o}));
  // R3
  ramp_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_start_o |-> (tx_amp_en_o && !$past(tx_amp_en_o)));
  // R4
  mod_after_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_start_o |-> (tx_amp_en_o && $past(tx_amp_en_o)));
  // R9
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!radio_active_o && !ramp_start_o && !mod_start_o && !rx_timeout_o));
  // R7
  tmo_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_timeout_o |-> (!radio_active_o && $past(rx_amp_en_o)));
  // R5
  tx_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_amp_en_o) |-> $past(tx_done_i || abort_i));
  // R8
  rx_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_amp_en_o) |-> ($past(rx_done_i || abort_i) || rx_timeout_o));
endmodule

bind radio_seq_top radio_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_done_i      (tx_done_i),
  .rx_done_i      (rx_done_i),
  .abort_i        (abort_i),
  .radio_active_o (radio_active_o),
  .rx_amp_en_o    (rx_amp_en_o),
  .tx_amp_en_o    (tx_amp_en_o),
  .ramp_start_o   (ramp_start_o),
  .mod_start_o    (mod_start_o),
  .rx_timeout_o   (rx_timeout_o)
);

// File: tb/radio_seq_top_tb_top.sv
`timescale 1ns/1ps
module radio_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tb = 32'hFFFF_F000;
  logic        tx_arm = 0, rx_arm = 0, sync = 0, tx_done = 0, rx_done = 0, abort = 0;
  logic [31:0] tx_start = 0, rx_start = 0;
  logic [15:0] idle = 0, ramp = 0, win = 0;
  logic        act, rxen, txen, rmp, mod, tmo;

  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  radio_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .timebase_i(tb),
    .tx_arm_i(tx_arm), .tx_start_time_i(tx_start), .tx_idle_dly_i(idle), .tx_ramp_len_i(ramp),
    .rx_arm_i(rx_arm), .rx_start_time_i(rx_start), .rx_window_len_i(win),
    .sync_det_i(sync), .tx_done_i(tx_done), .rx_done_i(rx_done), .abort_i(abort),
    .radio_active_o(act), .rx_amp_en_o(rxen), .tx_amp_en_o(txen),
    .ramp_start_o(rmp), .mod_start_o(mod), .rx_timeout_o(tmo)
  );

  always @(posedge clk) tb <= tb + 32'd1;

  // ---------------- reference model ----------------
  int          m_ph = 0;  // 0 idle,1 txw,2 txd,3 ramp,4 mod,5 rxw,6 win,7 sync
  logic [31:0] m_a = 0, m_b = 0, m_c = 0;
  bit          e_rmp = 0, e_mod = 0, e_tmo = 0;

  function automatic bit due(input logic [31:0] now, input logic [31:0] t);
    logic [31:0] d;
    d = now - t;
    return !d[31];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; e_rmp = 0; e_mod = 0; e_tmo = 0;
    end else begin
      int nx;
      nx = m_ph; e_rmp = 0; e_mod = 0; e_tmo = 0;
      if (abort) nx = 0;
      else if (m_ph == 0) begin
        if (tx_arm) begin
          nx = 1; m_a = tx_start; m_b = tx_start + 32'(idle); m_c = m_b + 32'(ramp);
        end else if (rx_arm) begin
          nx = 5; m_a = rx_start; m_b = rx_start + 32'(win);
        end
      end
      else if (m_ph == 1) begin if (due(tb, m_a)) nx = 2; end
      else if (m_ph == 2) begin if (due(tb, m_b)) begin nx = 3; e_rmp = 1; end end
      else if (m_ph == 3) begin if (due(tb, m_c)) begin nx = 4; e_mod = 1; end end
      else if (m_ph == 4) begin if (tx_done) nx = 0; end
      else if (m_ph == 5) begin if (due(tb, m_a)) nx = 6; end
      else if (m_ph == 6) begin
        if (sync) nx = 7;
        else if (due(tb, m_b)) begin nx = 0; e_tmo = 1; end
      end
      else if (m_ph == 7) begin if (rx_done) nx = 0; end
      m_ph = nx;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  // ---------------- per-cycle compare and event log ----------------
  logic [31:0] t_act = 0, t_txen = 0, t_rxen = 0, t_rmp = 0, t_mod = 0, t_tmo = 0;
  int n_act = 0, n_txen = 0, n_rxen = 0, n_rmp = 0, n_mod = 0, n_tmo = 0;
  logic p_act = 0, p_txen = 0, p_rxen = 0;

  always @(negedge clk) begin
    bit x_act, x_tx, x_rx;
    x_act = (m_ph == 2) || (m_ph == 3) || (m_ph == 4) || (m_ph == 6) || (m_ph == 7);
    x_tx  = (m_ph == 3) || (m_ph == 4);
    x_rx  = (m_ph == 6) || (m_ph == 7);
    chk(act == x_act, "R2 radio_active", 32'(act), 32'(x_act));
    chk(txen == x_tx, "R3 tx_amp_en", 32'(txen), 32'(x_tx));
    chk(rxen == x_rx, "R6 rx_amp_en", 32'(rxen), 32'(x_rx));
    chk(rmp == e_rmp, "R3 ramp_start", 32'(rmp), 32'(e_rmp));
    chk(mod == e_mod, "R4 mod_start", 32'(mod), 32'(e_mod));
    chk(tmo == e_tmo, "R7 rx_timeout", 32'(tmo), 32'(e_tmo));
    chk(!(rxen && txen), "R12 exclusive enables", {rxen, txen}, 0);
    // timestamps are the timebase sampled at the edge that caused the event
    if (act && !p_act)   begin t_act  = tb - 1; n_act++;  end
    if (txen && !p_txen) begin t_txen = tb - 1; n_txen++; end
    if (rxen && !p_rxen) begin t_rxen = tb - 1; n_rxen++; end
    if (rmp) begin t_rmp = tb - 1; n_rmp++; end
    if (mod) begin t_mod = tb - 1; n_mod++; end
    if (tmo) begin t_tmo = tb - 1; n_tmo++; end
    p_act = act; p_txen = txen; p_rxen = rxen;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(negedge clk); #1; endtask
  task automatic steps(input int n); for (int i = 0; i < n; i++) step(); endtask
  task automatic arm_tx(input logic [31:0] s, input logic [15:0] i, input logic [15:0] r);
    tx_start = s; idle = i; ramp = r; tx_arm = 1; step(); tx_arm = 0;
  endtask
  task automatic arm_rx(input logic [31:0] s, input logic [15:0] w);
    rx_start = s; win = w; rx_arm = 1; step(); rx_arm = 0;
  endtask
  task automatic pulse_tx_done(); tx_done = 1; step(); tx_done = 0; endtask
  task automatic pulse_rx_done(); rx_done = 1; step(); rx_done = 0; endtask
  task automatic pulse_abort();   abort = 1;   step(); abort = 0;   endtask
  task automatic wait_mod(input int base);
    for (int i = 0; i < 300 && n_mod == base; i++) step();
  endtask

  initial begin
    logic [31:0] s, a;
    int b_mod, b_rmp, b_act, b_rx, b_tx, b_tmo;
    steps(4);
    rst_n = 1;
    step();
    // R1
    chk({act, rxen, txen, rmp, mod, tmo} == 6'b0, "R1 outputs after reset", {act, rxen, txen, rmp, mod, tmo}, 0);

    // R2 R3 R4 R5: nominal transmit
    b_mod = n_mod; s = tb + 20;
    arm_tx(s, 16'd10, 16'd5);
    wait_mod(b_mod);
    chk(t_act == s, "R2 active at start", t_act, s);
    chk(t_txen == s + 10, "R2 tx amp low through delay", t_txen, s + 10);
    chk(t_rmp == s + 10, "R3 ramp at start+delay", t_rmp, s + 10);
    chk(t_mod == s + 15, "R4 mod at start+delay+ramp", t_mod, s + 15);
    steps(10);
    chk(txen == 1, "R4 tx amp held until done", 32'(txen), 1);
    pulse_tx_done();
    chk({act, txen} == 2'b0, "R5 idle after tx done", {act, txen}, 0);

    // R6 R7: receive timeout
    b_tmo = n_tmo; s = tb + 15;
    arm_rx(s, 16'd25);
    for (int i = 0; i < 100 && n_tmo == b_tmo; i++) step();
    chk(t_rxen == s, "R6 rx window opens at start", t_rxen, s);
    chk(t_tmo == s + 25, "R7 timeout at start+window", t_tmo, s + 25);
    chk({act, rxen} == 2'b0, "R7 enables cleared on timeout", {act, rxen}, 0);

    // R8: sync stops window
    b_tmo = n_tmo; b_rx = n_rxen; s = tb + 10;
    arm_rx(s, 16'd30);
    for (int i = 0; i < 50 && n_rxen == b_rx; i++) step();
    steps(5);
    sync = 1; step(); sync = 0;
    steps(60);
    chk(rxen == 1 && n_tmo == b_tmo, "R8 no timeout after sync", {rxen, 31'(n_tmo - b_tmo)}, 32'h8000_0000);
    pulse_rx_done();
    chk({act, rxen} == 2'b0, "R8 idle after rx done", {act, rxen}, 0);

    // R9: abort during ramp
    b_mod = n_mod; b_rmp = n_rmp; s = tb + 5;
    arm_tx(s, 16'd5, 16'd40);
    for (int i = 0; i < 50 && n_rmp == b_rmp; i++) step();
    steps(3);
    pulse_abort();
    chk({act, txen, rmp, mod} == 4'b0, "R9 abort clears tx", {act, txen, rmp, mod}, 0);
    steps(60);
    chk(n_mod == b_mod, "R9 no modulation after abort", n_mod - b_mod, 0);

    // R9: abort while waiting for receive start
    b_act = n_act; s = tb + 20;
    arm_rx(s, 16'd10);
    steps(3);
    pulse_abort();
    steps(40);
    chk(n_act == b_act, "R9 aborted rx never opens", n_act - b_act, 0);

    // R9: abort wins over arm
    b_act = n_act;
    tx_start = tb; idle = 1; ramp = 1; tx_arm = 1; abort = 1; step(); tx_arm = 0; abort = 0;
    steps(10);
    chk(n_act == b_act, "R9 abort beats arm", n_act - b_act, 0);

    // R10: start time in the past
    b_mod = n_mod; a = tb;
    arm_tx(a - 100, 16'd3, 16'd3);
    wait_mod(b_mod);
    chk(t_act == a + 1, "R10 past start fires next edge", t_act, a + 1);
    pulse_tx_done();

    // R11: rx arm ignored while tx busy
    b_mod = n_mod; b_rx = n_rxen; s = tb + 30;
    arm_tx(s, 16'd5, 16'd5);
    steps(5);
    arm_rx(tb + 2, 16'd100);
    wait_mod(b_mod);
    chk(n_rxen == b_rx, "R11 rx arm ignored when busy", n_rxen - b_rx, 0);
    chk(t_mod == s + 10, "R11 tx timing unchanged", t_mod, s + 10);
    pulse_tx_done();

    // R11: tx arm wins when both arrive together
    b_mod = n_mod; b_rx = n_rxen; b_tx = n_txen;
    tx_start = tb + 5; idle = 2; ramp = 2; rx_start = tb + 3; win = 50;
    tx_arm = 1; rx_arm = 1; step(); tx_arm = 0; rx_arm = 0;
    wait_mod(b_mod);
    chk(n_txen == b_tx + 1 && n_rxen == b_rx, "R11 tx priority", n_rxen - b_rx, 0);
    pulse_tx_done();

    // R10: deadlines across timebase rollover
    for (int i = 0; i < 5000 && tb != 32'hFFFF_FFF0; i++) step();
    b_mod = n_mod; s = tb + 32;
    arm_tx(s, 16'd8, 16'd8);
    steps(2);
    chk(act == 0, "R10 wrapped start not early", 32'(act), 0);
    wait_mod(b_mod);
    chk(t_act == s, "R10 wrapped start time", t_act, s);
    chk(t_mod == s + 16, "R10 wrapped modulation time", t_mod, s + 16);
    pulse_tx_done();
    steps(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule